// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Command Controller

This block sits behind a serial receiver that has already assembled 24-bit command words: an 8-bit control byte in bits 23:16 and a 16-bit data field in bits 15:0. For each of four converter channels it holds a staging (input) register and a live (DAC) register. Commands write the staging registers, write straight through to the live registers, copy staged values to live ones under a channel mask, clear everything, set per-channel power-down and the ready-enable bit, or set a linearity-tuning bit.

An asynchronous active-low load pin copies all staged values to the live registers. While the pin is held low, the path is transparent. A reset-select pin decides whether the live registers come up at zero or at midscale. A parameter builds a 12-bit variant in which the four least significant data bits are forced to zero. The outputs feed the analog converter, which lies outside this block.

Top module: `dacq_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every staging register becomes 0. Every live code becomes 0x8000 if `mid_sel` is 1 and 0x0000 if it is 0. `pd_mask_o` becomes 0, `rdy_en_o` becomes 1 and `lin_o` becomes 0.
- R2: A control byte 0x10–0x1F writes the data field into the staging register of each channel n whose control bit n (bits 3:0, bit 0 = channel 0) is 1. The live codes do not change.
- R3: A control byte 0x30–0x3F writes the data field into both the staging and the live register of each channel selected by bits 3:0. The new code appears on `code_o` one clock after the command.
- R4: Control byte 0x01 copies staging to live for each channel n whose data bit 8+n is 1. Channels whose bit is 0 keep their live code.
- R5: Control byte 0x02 has the effect of R1, using the value of `mid_sel` at that clock.
- R6: Control byte 0x03 loads `pd_mask_o` from data bits 11:8 (bit 8 = channel 0) and loads `rdy_en_o` from data bit 7.
- R7: Powering a channel down or back up leaves every live code unchanged.
- R8: `ref_off_o` is 1 exactly when all four bits of `pd_mask_o` are 1.
- R9: Control byte 0x05 loads `lin_o` from data bit 9.
- R10: Control byte 0x00 and every control byte that R2–R9 do not name change no output.
- R11: `load_n` passes through a two-flop synchronizer. The live codes are updated on the third rising edge after `load_n` falls. They do not change on the first two edges.
- R12: While the synchronized load is active, a staging write in the same clock also reaches the live register in that clock. A clear command in the same clock takes priority and leaves the R1 reset codes.
- R13: With `LOW_RES`=1, data bits 3:0 are ignored and stored as zero in both the staging and the live registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mid_sel | input | 1 | Reset code select: 1 = midscale, 0 = zero |
| load_n | input | 1 | Asynchronous active-low load of all live registers |
| cmd_valid | input | 1 | A command word is present this cycle |
| cmd_word | input | 24 | Control byte [23:16] and data [15:0] |
| code_o | output | 64 | Live codes; channel n occupies bits 16n+15:16n |
| pd_mask_o | output | 4 | Per-channel power-down mask |
| ref_off_o | output | 1 | Reference shutdown, all channels down |
| rdy_en_o | output | 1 | Ready output enable |
| lin_o | output | 1 | Linearity-tuning bit |

## Verification
The hardest case to reach is a hardware load that meets a serial command in the same clock. The bench can only create it by holding `load_n` low for longer than the synchronizer delay and then issuing commands while it stays low. It does this first with a staging write, which must appear live in one clock, and then with a clear, which must win over the load. A second instance built in the 12-bit variant shares the stimulus, so the bench can check that the low data bits are dropped.

// File: rtl/dacq_cmd_ctrl.sv
module dacq_cmd_ctrl #(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 16,
  parameter bit LOW_RES = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mid_sel,
  input  logic                     load_n,
  input  logic                     cmd_valid,
  input  logic [23:0]              cmd_word,
  output logic [NUM_CH*DATA_W-1:0] code_o,
  output logic [NUM_CH-1:0]        pd_mask_o,
  output logic                     ref_off_o,
  output logic                     rdy_en_o,
  output logic                     lin_o
);
  localparam logic [DATA_W-1:0] MID_CODE  = DATA_W'(1) << (DATA_W - 1);
  localparam int                DROP_BITS = LOW_RES ? 4 : 0;
  localparam logic [DATA_W-1:0] DATA_MASK = {DATA_W{1'b1}} << DROP_BITS;

  logic [7:0]        ctl;
  logic [DATA_W-1:0] wdata;
  logic [1:0]        ld_sync;
  logic              hw_ld;
  logic              is_wr, is_wt, is_ld, is_clr, is_pd, is_lin;
  logic [DATA_W-1:0] rst_code;

  assign ctl      = cmd_word[23:16];
  assign wdata    = cmd_word[DATA_W-1:0] & DATA_MASK;
  assign hw_ld    = ~ld_sync[1];
  assign rst_code = mid_sel ? MID_CODE : '0;

  assign is_wr  = cmd_valid && ctl[7:4] == 4'h1;
  assign is_wt  = cmd_valid && ctl[7:4] == 4'h3;
  assign is_ld  = cmd_valid && ctl == 8'h01;
  assign is_clr = cmd_valid && ctl == 8'h02;
  assign is_pd  = cmd_valid && ctl == 8'h03;
  assign is_lin = cmd_valid && ctl == 8'h05;

  logic [DATA_W-1:0] in_q  [NUM_CH];
  logic [DATA_W-1:0] dac_q [NUM_CH];
  logic [DATA_W-1:0] in_d  [NUM_CH];
  logic [DATA_W-1:0] dac_d [NUM_CH];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      in_d[i]  = in_q[i];
      dac_d[i] = dac_q[i];
      if ((is_wr || is_wt) && ctl[i]) in_d[i] = wdata;
      if (is_wt && ctl[i])            dac_d[i] = wdata;
      if (is_ld && cmd_word[8+i])     dac_d[i] = in_q[i];
      if (hw_ld)                      dac_d[i] = in_d[i];
      if (is_clr) begin
        in_d[i]  = '0;
        dac_d[i] = rst_code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_sync <= 2'b11;
      for (int i = 0; i < NUM_CH; i++) begin
        in_q[i]  <= '0;
        dac_q[i] <= rst_code;
      end
    end else begin
      ld_sync <= {ld_sync[0], load_n};
      for (int i = 0; i < NUM_CH; i++) begin
        in_q[i]  <= in_d[i];
        dac_q[i] <= dac_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || is_clr) begin
      pd_mask_o <= '0;
      rdy_en_o  <= 1'b1;
      lin_o     <= 1'b0;
    end else begin
      if (is_pd) begin
        pd_mask_o <= cmd_word[8 +: NUM_CH];
        rdy_en_o  <= cmd_word[7];
      end
      if (is_lin) lin_o <= cmd_word[9];
    end
  end

  assign ref_off_o = &pd_mask_o;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign code_o[g*DATA_W +: DATA_W] = dac_q[g];
  end

  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !hw_ld) |=> $stable(code_o));

  p_write_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wt && cmd_word[16]) |=> code_o[DATA_W-1:0] == ($past(cmd_word[DATA_W-1:0]) & DATA_MASK));

  p_clear_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> (pd_mask_o == '0 && !lin_o && rdy_en_o));

  p_pd_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_pd |=> pd_mask_o == $past(cmd_word[8 +: NUM_CH]));

  p_pd_keeps_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pd && !hw_ld) |=> $stable(code_o));

  p_unknown_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !(is_wr || is_wt || is_ld || is_clr || is_pd || is_lin) && !hw_ld)
      |=> ($stable(code_o) && $stable(pd_mask_o) && $stable(rdy_en_o) && $stable(lin_o)));
endmodule

// File: tb/dacq_cmd_ctrl_tb.sv
module dacq_cmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mid_sel = 1'b0;
  logic        load_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic [63:0] code_o, code12_o;
  logic [3:0]  pd_mask_o, pd12;
  logic        ref_off_o, rdy_en_o, lin_o, ro12, re12, li12;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  dacq_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .load_n(load_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .code_o(code_o),
    .pd_mask_o(pd_mask_o), .ref_off_o(ref_off_o), .rdy_en_o(rdy_en_o), .lin_o(lin_o));

  dacq_cmd_ctrl #(.LOW_RES(1'b1)) dut12_i (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .load_n(load_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .code_o(code12_o),
    .pd_mask_o(pd12), .ref_off_o(ro12), .rdy_en_o(re12), .lin_o(li12));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] c, logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {c, d};
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    mid_sel = m;
    rst_n   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset(logic m);
    do_reset(m);
    chk("R1 codes", code_o, {4{m ? 16'h8000 : 16'h0000}});
    chk("R1 flags", {pd_mask_o, ref_off_o, rdy_en_o, lin_o}, {4'h0, 1'b0, 1'b1, 1'b0});
    send(8'h01, 16'h0F00);
    chk("R1 staging zero", code_o, 64'h0);
  endtask

  task automatic t_write_and_load;
    do_reset(1'b0);
    send(8'h15, 16'h1234);
    chk("R2 live unchanged", code_o, 64'h0);
    send(8'h01, 16'h0100);
    chk("R4 ch0 only", code_o, 64'h0000_0000_0000_1234);
    send(8'h01, 16'h0E00);
    chk("R4 ch2 loaded", code_o, 64'h0000_1234_0000_1234);
    send(8'h3A, 16'hBEEF);
    chk("R3 write-through", code_o, 64'hBEEF_1234_BEEF_1234);
  endtask

  task automatic t_power;
    send(8'h03, 16'h0500);
    chk("R6 mask and ready", {pd_mask_o, rdy_en_o}, {4'h5, 1'b0});
    chk("R8 partial", {63'h0, ref_off_o}, 64'h0);
    chk("R7 codes kept", code_o, 64'hBEEF_1234_BEEF_1234);
    send(8'h03, 16'h0F80);
    chk("R8 all down", {pd_mask_o, ref_off_o, rdy_en_o}, {4'hF, 1'b1, 1'b1});
    send(8'h03, 16'h0080);
    chk("R7 restored", code_o, 64'hBEEF_1234_BEEF_1234);
    chk("R8 released", {63'h0, ref_off_o}, 64'h0);
  endtask

  task automatic t_lin_nop;
    send(8'h05, 16'h0200);
    chk("R9 set", {63'h0, lin_o}, 64'h1);
    send(8'h00, 16'hFFFF);
    send(8'h07, 16'hFFFF);
    send(8'h20, 16'hFFFF);
    send(8'hFF, 16'hFFFF);
    chk("R10 codes", code_o, 64'hBEEF_1234_BEEF_1234);
    chk("R10 flags", {pd_mask_o, rdy_en_o, lin_o}, {4'h0, 1'b1, 1'b1});
    send(8'h05, 16'hFDFF);
    chk("R9 clear", {63'h0, lin_o}, 64'h0);
  endtask

  task automatic t_hw_load;
    send(8'h1F, 16'h5555);
    @(negedge clk);
    load_n = 1'b0;
    @(negedge clk);
    chk("R11 edge1 hold", code_o, 64'hBEEF_1234_BEEF_1234);
    @(negedge clk);
    chk("R11 edge2 hold", code_o, 64'hBEEF_1234_BEEF_1234);
    @(negedge clk);
    chk("R11 loaded", code_o, {4{16'h5555}});
    send(8'h12, 16'h7777);
    chk("R12 transparent", code_o, 64'h5555_5555_7777_5555);
    send(8'h02, 16'h0000);
    chk("R12 clear wins", code_o, 64'h0);
    load_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_clear_mid;
    send(8'h3F, 16'h4321);
    send(8'h03, 16'h0F00);
    send(8'h05, 16'h0200);
    @(negedge clk);
    mid_sel = 1'b1;
    send(8'h02, 16'h0000);
    chk("R5 codes", code_o, {4{16'h8000}});
    chk("R5 flags", {pd_mask_o, ref_off_o, rdy_en_o, lin_o}, {4'h0, 1'b0, 1'b1, 1'b0});
    send(8'h01, 16'h0F00);
    chk("R5 staging zero", code_o, 64'h0);
  endtask

  task automatic t_low_res;
    send(8'h3F, 16'hABCD);
    chk("R13 full width", code_o, {4{16'hABCD}});
    chk("R13 low bits dropped", code12_o, {4{16'hABC0}});
  endtask

  initial begin
    t_reset(1'b0);
    t_write_and_load;
    t_power;
    t_lin_nop;
    t_hw_load;
    t_clear_mid;
    t_reset(1'b1);
    t_low_res;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule